// File: doc/BRIEF.md
# Ping-Pong Receive DMA Controller

This block drains a byte-wide receive FIFO into memory through two alternating buffers, A and B. Software gives a buffer a start address and a byte count, then pulses that buffer's load strobe. The active buffer takes one byte per accepted handshake and writes it to its start address plus its current offset. When it stores its last byte, the other buffer takes over in the same cycle if software has loaded it. If not, the block stops accepting bytes until a buffer is loaded.

Every byte from the FIFO carries three tags: frame error, parity error and overrun. Each tag sets a sticky flag that belongs to the buffer that took the byte. An overrun therefore lands on the buffer that was next due to load, once that buffer starts draining the FIFO. A buffer's flags clear when software loads that same buffer again, and all flags clear on reset. A read-only status word reports the flags, the receive-active bits and two transmit-active bits taken from outside. A separate output gives buffer A's write offset.

Top module: `pp_rx_dma`

## Requirements
- R1: After reset, `status` is 0 apart from the two transmit bits, which follow their inputs. `rxCntA` is 0, `fifoReady` is 0 and `memWe` is 0.
- R2: A load strobe is accepted only when its buffer is neither pending nor active and `cfgLen` is non-zero. Any other strobe is ignored and leaves the buffer's address, length and flags unchanged.
- R3: Buffer A is the first buffer due after reset, and the due buffer alternates A, B, A, B. While only the buffer that is not due is loaded, `fifoReady` stays 0.
- R4: Each accepted byte (`fifoValid` and `fifoReady` both high) produces exactly one `memWe` pulse in that cycle, with `memData` equal to the byte and `memAddr` equal to the buffer start address plus the offset.
- R5: After the active buffer writes its last byte, it stops being active from the next cycle. The other buffer is active in that same cycle if it is loaded. Otherwise `fifoReady` stays 0 until a buffer is loaded.
- R6: `status` bit 0 is 1 while buffer A is active and bit 1 is 1 while buffer B is active. Bits 2 (A) and 3 (B) mirror `txActA` and `txActB`.
- R7: A byte tagged with a frame error sets the frame flag of the buffer that takes it: bit 8 for A, bit 9 for B.
- R8: A byte tagged with a parity error sets the parity flag of the buffer that takes it: bit 6 for A, bit 7 for B.
- R9: A byte tagged with an overrun sets the overrun flag of the buffer that takes it, which is the buffer that was next due: bit 4 for A, bit 5 for B.
- R10: Error flags stay set until an accepted load of the same buffer clears them. A load of the other buffer leaves them set. Reset clears all flags.
- R11: `rxCntA` is the offset in buffer A where the next byte goes. It counts up by one for each byte that A takes, and returns to 0 when A writes its last byte.
- R12: `status` bits 15 to 10 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; also resets the receive DMA |
| cfgAddr | input | ADDR_W | Start address presented with a load strobe |
| cfgLen | input | CNT_W | Byte count presented with a load strobe |
| loadA | input | 1 | Load strobe for buffer A |
| loadB | input | 1 | Load strobe for buffer B |
| fifoValid | input | 1 | FIFO has a byte |
| fifoReady | output | 1 | Block accepts the byte |
| fifoData | input | 8 | Received byte |
| fifoFrm | input | 1 | Frame-error tag of the byte |
| fifoPar | input | 1 | Parity-error tag of the byte |
| fifoOvr | input | 1 | Overrun tag of the byte |
| memWe | output | 1 | Single-cycle memory write strobe |
| memAddr | output | ADDR_W | Write address |
| memData | output | 8 | Write data |
| txActA | input | 1 | Transmit buffer A active, from the transmit engine |
| txActB | input | 1 | Transmit buffer B active, from the transmit engine |
| status | output | 16 | Read-only status word |
| rxCntA | output | CNT_W | Next write offset in buffer A |

## Verification
The bench checks that the block stalls while only buffer B is loaded. A design that ignored the A-first order would write B's bytes at once. It checks that the hand-over at the last byte activates the waiting buffer with no idle gap, and that the offset returns to 0 there. A wrong count would move later bytes to the wrong address, and the scoreboard would catch it. Load strobes aimed at an active buffer, or carrying a zero length, are sent to confirm they change neither the addresses nor the flags. An overrun and a frame error are each put on the buffer that takes the byte, and a reload of the other buffer must leave them set. A design that cleared flags on any load, or that charged errors to the wrong buffer, would show the wrong status bits.

// File: rtl/pp_rx_pkg.sv
`timescale 1ns/1ps
package pp_rx_pkg;
  localparam int NUM_BUF = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic                xfer;  // byte accepted this cycle
    logic                sel;   // buffer taking it (0 = A, 1 = B)
    logic [NUM_BUF-1:0]  load;  // accepted load per buffer
  } dpStrobe_t;
endpackage

// File: rtl/pp_rx_ctrl.sv
`timescale 1ns/1ps
module pp_rx_ctrl
  import pp_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BUF-1:0] loadReq,
  input  logic               lenZero,
  input  logic               fifoValid,
  input  logic               fifoFrm,
  input  logic               fifoPar,
  input  logic               fifoOvr,
  input  logic               isLast,
  output logic               fifoReady,
  output dpStrobe_t          strobe,
  output logic [NUM_BUF-1:0] rxAct,
  output logic [NUM_BUF-1:0] frmErr,
  output logic [NUM_BUF-1:0] parErr,
  output logic [NUM_BUF-1:0] ovrErr
);
  logic               cur;     // buffer due / in use
  logic [NUM_BUF-1:0] loaded;  // pending or active
  logic [NUM_BUF-1:0] loadOk;
  logic               xfer;
  logic               unload;

  assign fifoReady = loaded[cur];
  assign xfer      = fifoValid & fifoReady;
  assign unload    = xfer & isLast;

  always_comb begin
    for (int i = 0; i < NUM_BUF; i++) begin
      loadOk[i] = loadReq[i] & ~loaded[i] & ~lenZero;
      rxAct[i]  = loaded[i] & (cur == i[0]);
    end
  end

  assign strobe.xfer = xfer;
  assign strobe.sel  = cur;
  assign strobe.load = loadOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cur    <= 1'b0;
      loaded <= '0;
      frmErr <= '0;
      parErr <= '0;
      ovrErr <= '0;
    end else begin
      if (unload) cur <= ~cur;
      for (int i = 0; i < NUM_BUF; i++) begin
        if (loadOk[i]) begin
          loaded[i] <= 1'b1;
          frmErr[i] <= 1'b0;
          parErr[i] <= 1'b0;
          ovrErr[i] <= 1'b0;
        end else if (xfer && cur == i[0]) begin
          if (isLast)  loaded[i] <= 1'b0;
          if (fifoFrm) frmErr[i] <= 1'b1;
          if (fifoPar) parErr[i] <= 1'b1;
          if (fifoOvr) ovrErr[i] <= 1'b1;
        end
      end
    end
  end

  // R5
  switch_buf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && isLast) |=> (cur != $past(cur)));

  // R10
  reload_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadOk[0] |=> (frmErr[0] == 1'b0 && parErr[0] == 1'b0 && ovrErr[0] == 1'b0));

  // R7
  frame_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && fifoFrm) |=> frmErr[$past(cur)]);

  // R9
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && fifoOvr) |=> ovrErr[$past(cur)]);

  // R6
  one_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rxAct));
endmodule

// File: rtl/pp_rx_dp.sv
`timescale 1ns/1ps
module pp_rx_dp
  import pp_rx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgLen,
  input  logic [7:0]        fifoData,
  output logic              isLast,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [CNT_W-1:0]  cntA
);
  logic [ADDR_W-1:0] baseQ [NUM_BUF];
  logic [CNT_W-1:0]  lenQ  [NUM_BUF];
  logic [CNT_W-1:0]  offQ  [NUM_BUF];

  assign isLast  = (offQ[strobe.sel] == lenQ[strobe.sel] - CNT_W'(1));
  assign memWe   = strobe.xfer;
  assign memAddr = baseQ[strobe.sel] + ADDR_W'(offQ[strobe.sel]);
  assign memData = fifoData;
  assign cntA    = offQ[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        baseQ[i] <= '0;
        lenQ[i]  <= '0;
        offQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (strobe.load[i]) begin
          baseQ[i] <= cfgAddr;
          lenQ[i]  <= cfgLen;
          offQ[i]  <= '0;
        end else if (strobe.xfer && strobe.sel == i[0]) begin
          offQ[i] <= isLast ? '0 : offQ[i] + CNT_W'(1);
        end
      end
    end
  end

  // R11
  offset_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.xfer && !strobe.sel && isLast) |=> (offQ[0] == '0));

  // R11
  offset_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.xfer && !strobe.sel && !isLast && !strobe.load[0])
      |=> (offQ[0] == $past(offQ[0]) + CNT_W'(1)));
endmodule

// File: rtl/pp_rx_dma.sv
`timescale 1ns/1ps
module pp_rx_dma
  import pp_rx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgLen,
  input  logic              loadA,
  input  logic              loadB,
  input  logic              fifoValid,
  output logic              fifoReady,
  input  logic [7:0]        fifoData,
  input  logic              fifoFrm,
  input  logic              fifoPar,
  input  logic              fifoOvr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  input  logic              txActA,
  input  logic              txActB,
  output logic [15:0]       status,
  output logic [CNT_W-1:0]  rxCntA
);
  dpStrobe_t          strobe;
  logic               isLast;
  logic [NUM_BUF-1:0] rxAct, frmErr, parErr, ovrErr;

  pp_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .loadReq({loadB, loadA}), .lenZero(cfgLen == '0),
    .fifoValid(fifoValid), .fifoFrm(fifoFrm), .fifoPar(fifoPar), .fifoOvr(fifoOvr),
    .isLast(isLast), .fifoReady(fifoReady), .strobe(strobe),
    .rxAct(rxAct), .frmErr(frmErr), .parErr(parErr), .ovrErr(ovrErr)
  );

  pp_rx_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgAddr(cfgAddr), .cfgLen(cfgLen), .fifoData(fifoData),
    .isLast(isLast), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .cntA(rxCntA)
  );

  assign status = {6'b0, frmErr[1], frmErr[0], parErr[1], parErr[0],
                   ovrErr[1], ovrErr[0], txActB, txActA, rxAct[1], rxAct[0]};

  // R4
  write_needs_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (fifoValid && fifoReady));
endmodule

// File: tb/test_pp_rx_dma.sv
`timescale 1ns/1ps
module test_pp_rx_dma;
  localparam int AW = 16;
  localparam int CW = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] cfgAddr = '0;
  logic [CW-1:0] cfgLen = '0;
  logic loadA = 1'b0, loadB = 1'b0;
  logic fifoValid = 1'b0, fifoFrm = 1'b0, fifoPar = 1'b0, fifoOvr = 1'b0;
  logic [7:0] fifoData = '0;
  logic txActA = 1'b0, txActB = 1'b0;
  logic fifoReady, memWe;
  logic [AW-1:0] memAddr;
  logic [7:0] memData;
  logic [15:0] status;
  logic [CW-1:0] rxCntA;

  pp_rx_dma #(.ADDR_W(AW), .CNT_W(CW)) i_pp_rx_dma (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgLen(cfgLen),
    .loadA(loadA), .loadB(loadB), .fifoValid(fifoValid), .fifoReady(fifoReady),
    .fifoData(fifoData), .fifoFrm(fifoFrm), .fifoPar(fifoPar), .fifoOvr(fifoOvr),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .txActA(txActA), .txActB(txActB), .status(status), .rxCntA(rxCntA)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [23:0] expQ[$];  // {addr, data}

  // model of buffer sequencing
  logic          mLoaded [2] = '{1'b0, 1'b0};
  int            mCur = 0;
  logic [AW-1:0] mBase [2];
  int            mLen [2];
  int            mOff [2] = '{0, 0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic loadBuf(input int sel, input logic [AW-1:0] a, input int len);
    @(negedge clk);
    cfgAddr = a;
    cfgLen  = CW'(len);
    if (sel == 0) loadA = 1'b1; else loadB = 1'b1;
    if (!mLoaded[sel] && len != 0) begin
      mLoaded[sel] = 1'b1;
      mBase[sel]   = a;
      mLen[sel]    = len;
      mOff[sel]    = 0;
    end
    @(negedge clk);
    loadA = 1'b0;
    loadB = 1'b0;
  endtask

  // driver: pushes expected write, then performs the handshake
  task automatic sendByte(input logic [7:0] d, input logic f, input logic p, input logic o);
    int w;
    @(negedge clk);
    fifoValid = 1'b1; fifoData = d; fifoFrm = f; fifoPar = p; fifoOvr = o;
    expQ.push_back({mBase[mCur] + AW'(mOff[mCur]), d});
    mOff[mCur]++;
    if (mOff[mCur] == mLen[mCur]) begin
      mOff[mCur] = 0;
      mLoaded[mCur] = 1'b0;
      mCur ^= 1;
    end
    w = 0;
    #1;
    while (!fifoReady && w < 50) begin
      @(negedge clk); #1;
      w++;
    end
    if (w >= 50) chk("R3 handshake never ready", {31'b0, fifoReady}, 32'd1);
    @(posedge clk); #0.5;
    fifoValid = 1'b0; fifoFrm = 1'b0; fifoPar = 1'b0; fifoOvr = 1'b0;
  endtask

  // monitor: compares each memory write with the scoreboard
  initial begin
    forever begin
      @(negedge clk); #1;
      if (memWe) begin
        if (expQ.size() == 0) begin
          chk("R4 unexpected write", {8'b0, memAddr, memData}, 32'hFFFF_FFFF);
        end else begin
          logic [23:0] e;
          e = expQ.pop_front();
          chk("R4 write addr/data", {8'b0, memAddr, memData}, {8'b0, e});
        end
      end
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    settle();
    chk("R1 status", {16'b0, status}, 32'h0);
    chk("R1 rxCntA", {19'b0, rxCntA}, 32'h0);
    chk("R1 ready", {31'b0, fifoReady}, 32'h0);
    chk("R1 memWe", {31'b0, memWe}, 32'h0);
    chk("R12 upper bits", {26'b0, status[15:10]}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    // R3 B loaded alone must not start
    loadBuf(1, 16'h0400, 2);
    settle();
    chk("R3 B not active", {16'b0, status}, 32'h0);
    chk("R3 ready low", {31'b0, fifoReady}, 32'h0);

    // R6 A takes over, tx bits mirror inputs
    loadBuf(0, 16'h0100, 3);
    settle();
    chk("R6 A active", {16'b0, status}, 32'h1);
    txActA = 1'b1;
    settle();
    chk("R6 txA bit", {16'b0, status}, 32'h5);
    txActA = 1'b0; txActB = 1'b1;
    settle();
    chk("R6 txB bit", {16'b0, status}, 32'h9);

    // R11 offset counting, R7/R8 flags on A
    sendByte(8'h11, 1'b0, 1'b0, 1'b0);
    settle();
    chk("R11 offset after one", {19'b0, rxCntA}, 32'd1);
    sendByte(8'h22, 1'b1, 1'b0, 1'b0);
    sendByte(8'h33, 1'b0, 1'b1, 1'b0);
    settle();
    chk("R11 offset wraps", {19'b0, rxCntA}, 32'd0);
    chk("R5/R7/R8 B active, A flags", {16'b0, status}, 32'h14A);

    // R2 ignored loads: zero length, and reload of active B
    loadBuf(0, 16'h0700, 0);
    loadBuf(1, 16'h0900, 5);
    settle();
    chk("R2 ignored loads keep status", {16'b0, status}, 32'h14A);

    // R9 overrun on B, B ends after its original 2 bytes
    sendByte(8'h44, 1'b0, 1'b0, 1'b1);
    sendByte(8'h55, 1'b0, 1'b0, 1'b0);
    settle();
    chk("R9 overrun B, R5 idle", {16'b0, status}, 32'h168);
    chk("R2 zero-length A not loaded", {31'b0, fifoReady}, 32'h0);

    // R5 stall with valid held high
    @(negedge clk); fifoValid = 1'b1; fifoData = 8'hEE;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R5 stalled ready", {31'b0, fifoReady}, 32'h0);
      @(negedge clk);
    end
    fifoValid = 1'b0;

    // R10 reload of B clears B only; R3 A still due
    loadBuf(1, 16'h0200, 1);
    settle();
    chk("R10 B cleared A kept", {16'b0, status}, 32'h148);
    chk("R3 B waits for A", {31'b0, fifoReady}, 32'h0);
    loadBuf(0, 16'h0300, 1);
    settle();
    chk("R10 A cleared", {16'b0, status}, 32'h9);

    sendByte(8'h66, 1'b0, 1'b0, 1'b1);
    settle();
    chk("R9 overrun A, R5 B active", {16'b0, status}, 32'h1A);
    sendByte(8'h77, 1'b1, 1'b1, 1'b0);
    settle();
    chk("R7/R8 B flags", {16'b0, status}, 32'h298);

    // R10 reset clears all flags
    @(negedge clk); rstN = 1'b0;
    settle();
    chk("R10 reset clears flags", {16'b0, status}, 32'h8);
    chk("R1 rxCntA after reset", {19'b0, rxCntA}, 32'h0);
    chk("R4 scoreboard drained", expQ.size(), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule